// File: doc/BRIEF.md
# Single-Transaction DRAM Command Sequencer

This block walks exactly one DRAM access at a time through its whole life. The phases are opening the row, issuing the column command, streaming the data burst and closing the row again. A requester presents a row, a starting column, a direction flag and a burst length, and the length may be different for every access. Because only one access is ever in flight, the block needs neither a scheduler nor a command queue.

The block drives four single-cycle command strobes, each with the address that belongs to it:

- open-row
- column
- write-enable level
- close-row

During the burst it also drives a data-valid window in which the column address steps by one per beat. It ends every access with a done pulse.

All DRAM timing values are parameters in clock cycles, and each must be at least 2:

- row-to-column delay `T_RCD`
- column latency `T_CL`
- minimum row-open time `T_RAS`
- close-row recovery time `T_RP`

At a 1066 MHz command clock, a 12.5 ns delay rounds up to 14 cycles.

The controller states are:

- IDLE: waiting for a request.
- OPEN: open-row strobe.
- WAIT_RC: row-to-column wait.
- COLCMD: column strobe.
- WAIT_CL: column latency.
- BURST: data beats.
- HOLD_ROW: waiting out the minimum row-open time.
- CLOSE: close-row strobe.
- WAIT_PC: close-row recovery.
- FINISH: done pulse, ready again.
- REJECT: error pulse.

The transitions are:

- IDLE or FINISH goes to OPEN on an accepted non-zero request.
- IDLE or FINISH goes to REJECT on a zero-length request.
- IDLE or FINISH goes to IDLE otherwise.
- OPEN goes to WAIT_RC.
- WAIT_RC goes to COLCMD when the delay expires.
- COLCMD goes to WAIT_CL.
- WAIT_CL goes to BURST when the latency expires.
- BURST goes to CLOSE on the last beat if the row-open time has also expired.
- BURST goes to HOLD_ROW on the last beat if the row-open time has not expired.
- HOLD_ROW goes to CLOSE when the row-open time expires.
- CLOSE goes to WAIT_PC.
- WAIT_PC goes to FINISH when recovery expires.
- REJECT goes to IDLE.

Top module: `dram_txn_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `cmd_act`, `cmd_cas`, `cmd_we`, `cmd_pre`, `data_valid`, `data_wr`, `txn_done` and `txn_err` are all 0.
- R2: A request with `req_valid` and `req_ready` both high and a non-zero `req_len` is accepted at that clock edge. In the next cycle `cmd_act` is 1 for one cycle, `cmd_row` equals the requested row, and `req_ready` is 0.
- R3: `cmd_cas` is 1 for one cycle exactly `T_RCD` cycles after `cmd_act`. In that cycle `cmd_col` is the starting column and `cmd_we` equals the direction flag (1 = write); `cmd_we` is 0 in every other cycle.
- R4: The first data beat comes exactly `T_CL` cycles after `cmd_cas`. `data_valid` is then 1 for exactly `req_len` consecutive cycles, and `data_wr` equals `data_valid` AND the direction flag.
- R5: During the burst `cmd_col` starts at the starting column and rises by one each beat, modulo 2^`COL_W`.
- R6: `cmd_pre` is 1 for one cycle, in the first cycle that is both at least `T_RAS` cycles after `cmd_act` and after the last data beat.
- R7: `txn_done` is 1 for one cycle, and `req_ready` returns to 1 in that same cycle, exactly `T_RP` cycles after `cmd_pre`. The next `cmd_act` comes at least `T_RP`+1 cycles after `cmd_pre`.
- R8: A request with `req_len` = 0 gives a one-cycle `txn_err` in the next cycle with no command strobe; `req_ready` is 0 in that cycle and 1 in the cycle after.
- R9: While `req_ready` is 0, `req_valid` and the request fields have no effect on the strobes, addresses or timing of the access in progress, and cause no later access.
- R10: In any cycle at most one of `cmd_act`, `cmd_cas`, `cmd_pre`, `data_valid` is 1, and each access raises `cmd_act`, `cmd_cas` and `cmd_pre` exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column |
| req_write | input | 1 | Direction flag, 1 = write |
| req_len | input | BL_W | Burst length in beats, 0 is rejected |
| cmd_act | output | 1 | Open-row strobe |
| cmd_row | output | ROW_W | Row address accompanying the open-row strobe |
| cmd_cas | output | 1 | Column strobe |
| cmd_we | output | 1 | Write-enable level, valid with the column strobe |
| cmd_col | output | COL_W | Column address: starting column at the column strobe, then one per beat |
| cmd_pre | output | 1 | Close-row strobe |
| data_valid | output | 1 | Data beat window |
| data_wr | output | 1 | Beat is a write (the controller drives the bus) |
| txn_done | output | 1 | Access finished pulse |
| txn_err | output | 1 | Zero-length request rejected pulse |

## Verification
The hardest conditions to reach from the ports are the close-row decision in its three orderings and the back-to-back hand-off. In the first ordering the burst ends before the row-open time, so the block must sit in HOLD_ROW. In the second the burst ends after the row-open time, so the block must go straight to CLOSE. In the third both end together. The hand-off is a new request accepted in the very FINISH cycle of the previous access.

The bench sweeps every burst length of a 4-bit length field in both directions, with small timing parameters. That sweep passes through all three orderings. Each new request is raised as soon as ready is seen, so every access after the first is accepted back to back. Starting columns near the top of the column space force the address to wrap. One access holds a changing request on the inputs throughout its busy period.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPEN,
        ST_WAIT_RC,
        ST_COLCMD,
        ST_WAIT_CL,
        ST_BURST,
        ST_HOLD_ROW,
        ST_CLOSE,
        ST_WAIT_PC,
        ST_FINISH,
        ST_REJECT
    } seq_state_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dseq_down_cnt.sv
module dseq_down_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/dseq_col_gen.sv
module dseq_col_gen #(
    parameter int COL_W = 10,
    parameter int BL_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [BL_W-1:0]  start_len,
    input  logic             step,
    output logic [COL_W-1:0] col,
    output logic             last
);

    logic [BL_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col    <= '0;
            left_q <= '0;
        end else if (start) begin
            col    <= start_col;
            left_q <= start_len;
        end else if (step) begin
            col    <= col + 1'b1;
            if (left_q != '0) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign last = (left_q == BL_W'(1));

    // R4
    no_extra_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (left_q != '0));

endmodule

// File: rtl/dram_txn_seq.sv
module dram_txn_seq
    import dseq_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    parameter int BL_W  = 8,
    parameter int T_RCD = 14,
    parameter int T_CL  = 14,
    parameter int T_RP  = 14,
    parameter int T_RAS = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_write,
    input  logic [BL_W-1:0]  req_len,
    output logic             cmd_act,
    output logic [ROW_W-1:0] cmd_row,
    output logic             cmd_cas,
    output logic             cmd_we,
    output logic [COL_W-1:0] cmd_col,
    output logic             cmd_pre,
    output logic             data_valid,
    output logic             data_wr,
    output logic             txn_done,
    output logic             txn_err
);

    localparam int MAXT  = max4(T_RCD, T_CL, T_RP, T_RAS);
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam int AW    = $clog2(MAXT + 3) + 1;

    seq_state_e st_q, st_d;

    logic             accept;
    logic             reject;
    logic [ROW_W-1:0] row_q;
    logic             wr_q;
    logic             ph_load;
    logic [CNT_W-1:0] ph_val;
    logic [CNT_W-1:0] ph_cnt;
    logic             ras_load;
    logic [CNT_W-1:0] ras_cnt;
    logic             beat_last;
    logic [COL_W-1:0] col_cur;
    logic             ph_expiring;
    logic             ras_expiring;

    assign accept       = req_valid && req_ready && (req_len != '0);
    assign reject       = req_valid && req_ready && (req_len == '0);
    assign ph_expiring  = (ph_cnt <= CNT_W'(1));
    assign ras_expiring = (ras_cnt <= CNT_W'(1));

    dseq_down_cnt #(.W(CNT_W)) i_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .cnt      (ph_cnt)
    );

    dseq_down_cnt #(.W(CNT_W)) i_ras_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ras_load),
        .load_val (CNT_W'(T_RAS - 1)),
        .cnt      (ras_cnt)
    );

    dseq_col_gen #(.COL_W(COL_W), .BL_W(BL_W)) i_col_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_col (req_col),
        .start_len (req_len),
        .step      (data_valid),
        .col       (col_cur),
        .last      (beat_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
            wr_q  <= 1'b0;
        end else if (accept) begin
            row_q <= req_row;
            wr_q  <= req_write;
        end
    end

    // Next state and counter loads
    always_comb begin
        st_d     = st_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        ras_load = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_FINISH: begin
                if (accept)      st_d = ST_OPEN;
                else if (reject) st_d = ST_REJECT;
                else             st_d = ST_IDLE;
            end
            ST_OPEN: begin
                st_d     = ST_WAIT_RC;
                ph_load  = 1'b1;
                ph_val   = CNT_W'(T_RCD - 1);
                ras_load = 1'b1;
            end
            ST_WAIT_RC: begin
                if (ph_expiring) st_d = ST_COLCMD;
            end
            ST_COLCMD: begin
                st_d    = ST_WAIT_CL;
                ph_load = 1'b1;
                ph_val  = CNT_W'(T_CL - 1);
            end
            ST_WAIT_CL: begin
                if (ph_expiring) st_d = ST_BURST;
            end
            ST_BURST: begin
                if (beat_last) begin
                    st_d = ras_expiring ? ST_CLOSE : ST_HOLD_ROW;
                end
            end
            ST_HOLD_ROW: begin
                if (ras_expiring) st_d = ST_CLOSE;
            end
            ST_CLOSE: begin
                st_d    = ST_WAIT_PC;
                ph_load = 1'b1;
                ph_val  = CNT_W'(T_RP - 1);
            end
            ST_WAIT_PC: begin
                if (ph_expiring) st_d = ST_FINISH;
            end
            ST_REJECT: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_ready  = 1'b0;
        cmd_act    = 1'b0;
        cmd_cas    = 1'b0;
        cmd_we     = 1'b0;
        cmd_pre    = 1'b0;
        data_valid = 1'b0;
        data_wr    = 1'b0;
        txn_done   = 1'b0;
        txn_err    = 1'b0;
        unique case (st_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_OPEN:     cmd_act   = 1'b1;
            ST_WAIT_RC:  ;
            ST_COLCMD: begin
                cmd_cas = 1'b1;
                cmd_we  = wr_q;
            end
            ST_WAIT_CL:  ;
            ST_BURST: begin
                data_valid = 1'b1;
                data_wr    = wr_q;
            end
            ST_HOLD_ROW: ;
            ST_CLOSE:    cmd_pre = 1'b1;
            ST_WAIT_PC:  ;
            ST_FINISH: begin
                txn_done  = 1'b1;
                req_ready = 1'b1;
            end
            ST_REJECT:   txn_err = 1'b1;
            default:     ;
        endcase
    end

    assign cmd_row = row_q;
    assign cmd_col = col_cur;

    // Spacing monitors used only by the assertions below
    logic [AW-1:0] since_act, since_cas, since_pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_act <= '0;
            since_cas <= '0;
            since_pre <= '1;
        end else begin
            if (cmd_act)               since_act <= AW'(1);
            else if (since_act != '1)  since_act <= since_act + 1'b1;
            if (cmd_cas)               since_cas <= AW'(1);
            else if (since_cas != '1)  since_cas <= since_cas + 1'b1;
            if (cmd_pre)               since_pre <= AW'(1);
            else if (since_pre != '1)  since_pre <= since_pre + 1'b1;
        end
    end

    // R3
    cas_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cas |-> (since_act == AW'(T_RCD)));

    // R4
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !$past(data_valid)) |-> (since_cas == AW'(T_CL)));

    // R5
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid)) |-> (cmd_col == $past(cmd_col) + 1'b1));

    // R6
    pre_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre |-> ((since_act >= AW'(T_RAS)) && !$past(cmd_pre)));

    // R7
    act_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_act |-> (since_pre > AW'(T_RP)));

    // R8
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len == '0)) |=> (txn_err && !cmd_act && !req_ready));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (!cmd_act && !txn_err));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_act, cmd_cas, cmd_pre, data_valid}));

endmodule

// File: tb/test_dram_txn_seq.sv
module test_dram_txn_seq;

    localparam int ROW_W = 6;
    localparam int COL_W = 5;
    localparam int BL_W  = 4;
    localparam int T_RCD = 3;
    localparam int T_CL  = 2;
    localparam int T_RP  = 4;
    localparam int T_RAS = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_write = 1'b0;
    logic [BL_W-1:0]  req_len = '0;
    logic             cmd_act, cmd_cas, cmd_we, cmd_pre;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic             data_valid, data_wr, txn_done, txn_err;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_pre_cyc = -1;
    bit finished = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_txn_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .BL_W(BL_W),
        .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP), .T_RAS(T_RAS)
    ) i_dram_txn_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_row    (req_row),
        .req_col    (req_col),
        .req_write  (req_write),
        .req_len    (req_len),
        .cmd_act    (cmd_act),
        .cmd_row    (cmd_row),
        .cmd_cas    (cmd_cas),
        .cmd_we     (cmd_we),
        .cmd_col    (cmd_col),
        .cmd_pre    (cmd_pre),
        .data_valid (data_valid),
        .data_wr    (data_wr),
        .txn_done   (txn_done),
        .txn_err    (txn_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic run_txn(input int row, input int col, input bit wr, input int len,
                           input bit noise);
        int kc, kd0, kl, kp, kdn;
        int n_act, n_cas, n_pre;
        int wait_n;
        wait_n = 0;
        while (!req_ready && wait_n < 200) begin
            @(negedge clk);
            wait_n++;
        end
        req_valid = 1'b1;
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        req_write = wr;
        req_len   = BL_W'(len);
        @(negedge clk);
        if (noise) begin
            req_row   = ~ROW_W'(row);
            req_col   = ~COL_W'(col);
            req_write = ~wr;
            req_len   = BL_W'(1);
        end else begin
            req_valid = 1'b0;
        end
        if (len == 0) begin
            // R8
            chk(txn_err == 1'b1, "R8", "txn_err", txn_err, 1);
            chk({cmd_act, cmd_cas, cmd_pre, data_valid} == 4'b0, "R8", "strobes",
                {cmd_act, cmd_cas, cmd_pre, data_valid}, 0);
            chk(req_ready == 1'b0, "R8", "ready_in_err", req_ready, 0);
            @(negedge clk);
            chk(req_ready == 1'b1, "R8", "ready_after", req_ready, 1);
            chk(txn_err == 1'b0, "R8", "err_width", txn_err, 0);
            return;
        end
        kc  = 1 + T_RCD;
        kd0 = kc + T_CL;
        kl  = kd0 + len - 1;
        kp  = (kl + 1 > 1 + T_RAS) ? kl + 1 : 1 + T_RAS;
        kdn = kp + T_RP;
        n_act = 0; n_cas = 0; n_pre = 0;
        for (int k = 1; k <= kdn; k++) begin
            bit e_dv;
            e_dv = (k >= kd0) && (k <= kl);
            n_act += int'(cmd_act);
            n_cas += int'(cmd_cas);
            n_pre += int'(cmd_pre);
            chk(cmd_act == (k == 1), "R2", "cmd_act", cmd_act, int'(k == 1));
            if (k == 1) begin
                chk(cmd_row == ROW_W'(row), "R2", "cmd_row", cmd_row, row);
                if (last_pre_cyc >= 0)
                    chk(cyc - last_pre_cyc >= T_RP + 1, "R7", "act_gap",
                        cyc - last_pre_cyc, T_RP + 1);
            end
            chk(cmd_cas == (k == kc), "R3", "cmd_cas", cmd_cas, int'(k == kc));
            chk(cmd_we == ((k == kc) && wr), "R3", "cmd_we", cmd_we, int'((k == kc) && wr));
            if (k == kc)
                chk(cmd_col == COL_W'(col), "R3", "cas_col", cmd_col, col);
            chk(data_valid == e_dv, "R4", "data_valid", data_valid, int'(e_dv));
            chk(data_wr == (e_dv && wr), "R4", "data_wr", data_wr, int'(e_dv && wr));
            if (e_dv)
                chk(cmd_col == COL_W'(col + k - kd0), "R5", "beat_col", cmd_col,
                    (col + k - kd0) % (1 << COL_W));
            chk(cmd_pre == (k == kp), "R6", "cmd_pre", cmd_pre, int'(k == kp));
            if (k == kp) last_pre_cyc = cyc;
            chk(txn_done == (k == kdn), "R7", "txn_done", txn_done, int'(k == kdn));
            chk(req_ready == (k == kdn), (noise ? "R9" : "R7"), "req_ready", req_ready,
                int'(k == kdn));
            chk(txn_err == 1'b0, "R9", "txn_err", txn_err, 0);
            if (noise && k == kp) req_valid = 1'b0;
            if (k < kdn) @(negedge clk);
        end
        // R10
        chk(n_act == 1 && n_cas == 1 && n_pre == 1, "R10", "strobe_count",
            n_act * 100 + n_cas * 10 + n_pre, 111);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=expired expected=complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1", "reset_ready", req_ready, 1);
        chk({cmd_act, cmd_cas, cmd_we, cmd_pre, data_valid, data_wr, txn_done, txn_err} == 8'b0,
            "R1", "reset_strobes",
            {cmd_act, cmd_cas, cmd_we, cmd_pre, data_valid, data_wr, txn_done, txn_err}, 0);

        for (int wr = 0; wr < 2; wr++) begin
            for (int len = 0; len < (1 << BL_W); len++) begin
                run_txn((len * 5 + wr) % (1 << ROW_W), (len * 7 + 20) % (1 << COL_W),
                        wr[0], len, 1'b0);
            end
        end
        // column wrap at top of space
        run_txn(63, 30, 1'b1, 5, 1'b0);
        run_txn(1, 31, 1'b0, 15, 1'b0);
        // busy-time request noise must not disturb the access
        run_txn(17, 4, 1'b0, 3, 1'b1);
        // R9: nothing further starts once the noisy access finishes
        repeat (T_RCD + T_CL + 4) begin
            @(negedge clk);
            chk(cmd_act == 1'b0 && data_valid == 1'b0, "R9", "idle_after_noise",
                cmd_act | data_valid, 0);
        end
        run_txn(9, 12, 1'b1, 8, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule